// File: doc/BRIEF.md
# Weighted-Sum Pass Sequencer with Synthesized Weight Clock

This block is the shared controller of a cell array that forms weighted sums of analog inputs in the time domain. Each cell turns its input into a pulse whose width tracks the input level. The cell uses that pulse to gate a counting clock, so the count it gathers is the pulse width multiplied by the clock frequency. The sequencer runs one template computation as a series of passes. Every pass covers two ramp cycles. The first ramp measures the shared minimum reference and counts one way. The second ramp measures the selected neighbour's input and counts the other way, so comparator offset and skew cancel out of the result.

Before every ramp the sequencer loads a tuning word into its own phase-accumulator synthesizer. The accumulator's top bit is the counting clock sent to all cells, so the word sets the weight of the current term. A small table holds one tuning word and one sign bit for each pass, and it can be written only while the block is idle. A job clears the cell counters first. The ramp enable then drops for a programmable gap before each ramp so that the ramp can discharge, and a done pulse follows the last ramp. A default build uses a 6-bit accumulator. With a 360 MHz reference, a word of 11 gives 61.9 MHz. An edge-detection job uses three passes with words 11, 28 and 11.

Top module: `wsum_pass_seq`

## Requirements
- R1: After reset, and whenever no job is running, ramp_en_o, cnt_clr_o, nbr_sel_o, wclk_o, busy_o and done_o are all 0.
- R2: In the cycle after start_i is sampled high in idle, cnt_clr_o is 1 for exactly one cycle and busy_o is 1. No ramp is active in that cycle.
- R3: Each pass has two ramps. Each ramp is preceded by gap_i cycles with ramp_en_o low (0 means 1) and lasts ramp_len_i cycles with ramp_en_o high (0 means 1). Both values are sampled at start.
- R4: ref_sel_o is 1 during the first ramp of a pass and its preceding gap. It is 0 during the second ramp and its preceding gap.
- R5: cnt_up_o is 0 for the first ramp and 1 for the second ramp of a pass when the pass's sign bit is 0. Both values are inverted when the sign bit is 1.
- R6: During pass p, nbr_sel_o has only bit p set. Passes run in order 0, 1, 2, and so on.
- R7: tune_o takes the word of the current pass during the gap and holds it steady while ramp_en_o is high. The accumulator restarts from zero at each ramp.
- R8: In ramp cycle k (counting from 0), wclk_o equals bit ACC_W-1 of (k·N mod 2^ACC_W), where N is the pass's tuning word. This gives a frequency of fclk·N/2^ACC_W.
- R9: done_o is 1 for exactly one cycle, in the cycle after the last ramp cycle. busy_o is 0 in that cycle.
- R10: Table writes (tbl_we_i, index tbl_addr_i, word tbl_word_i, sign tbl_neg_i) are ignored while a job runs.
- R11: start_i is ignored while a job runs and in the done cycle.
- R12: The pass count is sampled at start. A value of 0 runs one pass, and a value above PASS_MAX runs PASS_MAX passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a job (idle only) |
| n_pass_i | input | PW | Pass count for the next job |
| ramp_len_i | input | TIME_W | Ramp length in cycles |
| gap_i | input | TIME_W | Idle gap before each ramp, in cycles |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | AW | Table entry (pass index) |
| tbl_word_i | input | ACC_W | Tuning word to store |
| tbl_neg_i | input | 1 | Sign bit to store |
| ramp_en_o | output | 1 | Ramp active |
| ref_sel_o | output | 1 | 1 selects the minimum reference, 0 the input |
| cnt_up_o | output | 1 | Cell count direction, 1 = up |
| nbr_sel_o | output | PASS_MAX | One-hot neighbour select |
| cnt_clr_o | output | 1 | Cell counter clear |
| wclk_o | output | 1 | Weight clock (accumulator top bit) |
| tune_o | output | ACC_W | Tuning word currently loaded |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Job finished pulse |

## Verification
The bench walks every cycle of a job and compares each control line against a model built from the requirements. It also rebuilds the weight clock cycle by cycle from the accumulator equation.

The corner cases it targets are these:
- Tuning words of 0 and 2^ACC_W−1. A design that failed to clear the phase at each load would give a wrong first edge or a wrong pulse count.
- A negative-sign pass. A design with the sign handling wrong would count both halves in the wrong direction.
- Zero gap and zero ramp length. A design that did not treat these as one cycle would hang or wrap its timers.
- Pass counts of zero and above the maximum. These catch a design that runs no pass or selects an entry that does not exist.
- A table write during a job. A design that accepted it would load the new word on a later pass.
- A second start during a job. A design that accepted it would restart the job or raise cnt_clr_o again.

// File: rtl/wsum_pkg.sv
package wsum_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_GAP,
    ST_RAMP,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/wsum_pass_table.sv
module wsum_pass_table #(
  parameter int PASS_MAX = 4,
  parameter int ACC_W    = 6,
  localparam int AW      = (PASS_MAX > 1) ? $clog2(PASS_MAX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [ACC_W-1:0] wword_i,
  input  logic             wneg_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [ACC_W-1:0] rword_o,
  output logic             rneg_o
);
  logic [ACC_W-1:0] word_q [PASS_MAX];
  logic             neg_q  [PASS_MAX];

  for (genvar i = 0; i < PASS_MAX; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[i] <= '0;
        neg_q[i]  <= 1'b0;
      end else if (we_i && (waddr_i == AW'(i))) begin
        word_q[i] <= wword_i;
        neg_q[i]  <= wneg_i;
      end
    end
  end

  always_comb begin
    rword_o = '0;
    rneg_o  = 1'b0;
    for (int i = 0; i < PASS_MAX; i++) begin
      if (raddr_i == AW'(i)) begin
        rword_o = word_q[i];
        rneg_o  = neg_q[i];
      end
    end
  end
endmodule

// File: rtl/wsum_phase_acc.sv
module wsum_phase_acc #(
  parameter int ACC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [ACC_W-1:0] word_i,
  output logic [ACC_W-1:0] tune_o,
  output logic             msb_o
);
  logic [ACC_W-1:0] inc_q, phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q   <= '0;
      phase_q <= '0;
    end else begin
      if (load_i) inc_q <= word_i;
      // phase restarts from zero whenever no ramp runs
      if (run_i) phase_q <= phase_q + inc_q;
      else       phase_q <= '0;
    end
  end

  assign tune_o = inc_q;
  assign msb_o  = phase_q[ACC_W-1];
endmodule

// File: rtl/wsum_step_fsm.sv
module wsum_step_fsm
  import wsum_pkg::*;
#(
  parameter int PASS_MAX = 4,
  parameter int TIME_W   = 8,
  localparam int AW      = (PASS_MAX > 1) ? $clog2(PASS_MAX) : 1,
  localparam int PW      = $clog2(PASS_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PW-1:0]     n_pass_i,
  input  logic [TIME_W-1:0] ramp_len_i,
  input  logic [TIME_W-1:0] gap_i,
  output seq_st_e           st_o,
  output logic [AW-1:0]     pass_o,
  output logic              half_o
);
  localparam logic [PW-1:0]     P_MAX = PW'(PASS_MAX);
  localparam logic [PW-1:0]     P_ONE = PW'(1);
  localparam logic [TIME_W-1:0] T_ONE = TIME_W'(1);

  seq_st_e           st_q;
  logic [TIME_W-1:0] tmr_q, rl_q, gp_q;
  logic [PW-1:0]     np_q, np_eff;
  logic [AW-1:0]     pass_q;
  logic              half_q;
  logic              gap_end, ramp_end, last_pass;

  always_comb begin
    if (n_pass_i == '0)        np_eff = P_ONE;
    else if (n_pass_i > P_MAX) np_eff = P_MAX;
    else                       np_eff = n_pass_i;
  end

  assign gap_end   = (tmr_q == gp_q - T_ONE);
  assign ramp_end  = (tmr_q == rl_q - T_ONE);
  assign last_pass = (PW'(pass_q) == np_q - P_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      rl_q   <= T_ONE;
      gp_q   <= T_ONE;
      np_q   <= P_ONE;
      pass_q <= '0;
      half_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          np_q   <= np_eff;
          rl_q   <= (ramp_len_i == '0) ? T_ONE : ramp_len_i;
          gp_q   <= (gap_i == '0) ? T_ONE : gap_i;
          pass_q <= '0;
          half_q <= 1'b0;
          tmr_q  <= '0;
          st_q   <= ST_CLR;
        end
        ST_CLR: begin
          tmr_q <= '0;
          st_q  <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_end) begin
            tmr_q <= '0;
            st_q  <= ST_RAMP;
          end else begin
            tmr_q <= tmr_q + T_ONE;
          end
        end
        ST_RAMP: begin
          if (ramp_end) begin
            tmr_q <= '0;
            if (half_q && last_pass) begin
              st_q <= ST_DONE;
            end else begin
              st_q <= ST_GAP;
              if (half_q) begin
                half_q <= 1'b0;
                pass_q <= pass_q + AW'(1);
              end else begin
                half_q <= 1'b1;
              end
            end
          end else begin
            tmr_q <= tmr_q + T_ONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o   = st_q;
  assign pass_o = pass_q;
  assign half_o = half_q;
endmodule

// File: rtl/wsum_pass_seq.sv
module wsum_pass_seq
  import wsum_pkg::*;
#(
  parameter int ACC_W    = 6,
  parameter int PASS_MAX = 4,
  parameter int TIME_W   = 8,
  localparam int AW      = (PASS_MAX > 1) ? $clog2(PASS_MAX) : 1,
  localparam int PW      = $clog2(PASS_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PW-1:0]       n_pass_i,
  input  logic [TIME_W-1:0]   ramp_len_i,
  input  logic [TIME_W-1:0]   gap_i,
  input  logic                tbl_we_i,
  input  logic [AW-1:0]       tbl_addr_i,
  input  logic [ACC_W-1:0]    tbl_word_i,
  input  logic                tbl_neg_i,
  output logic                ramp_en_o,
  output logic                ref_sel_o,
  output logic                cnt_up_o,
  output logic [PASS_MAX-1:0] nbr_sel_o,
  output logic                cnt_clr_o,
  output logic                wclk_o,
  output logic [ACC_W-1:0]    tune_o,
  output logic                busy_o,
  output logic                done_o
);
  seq_st_e          st;
  logic [AW-1:0]    pass_idx;
  logic             half;
  logic             idle, active;
  logic [ACC_W-1:0] cur_word;
  logic             cur_neg;

  wsum_step_fsm #(.PASS_MAX(PASS_MAX), .TIME_W(TIME_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .n_pass_i   (n_pass_i),
    .ramp_len_i (ramp_len_i),
    .gap_i      (gap_i),
    .st_o       (st),
    .pass_o     (pass_idx),
    .half_o     (half)
  );

  assign idle   = (st == ST_IDLE);
  assign active = (st == ST_GAP) || (st == ST_RAMP);

  wsum_pass_table #(.PASS_MAX(PASS_MAX), .ACC_W(ACC_W)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i && idle),
    .waddr_i (tbl_addr_i),
    .wword_i (tbl_word_i),
    .wneg_i  (tbl_neg_i),
    .raddr_i (pass_idx),
    .rword_o (cur_word),
    .rneg_o  (cur_neg)
  );

  wsum_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (st == ST_GAP),
    .run_i  (st == ST_RAMP),
    .word_i (cur_word),
    .tune_o (tune_o),
    .msb_o  (wclk_o)
  );

  for (genvar i = 0; i < PASS_MAX; i++) begin : g_nbr
    assign nbr_sel_o[i] = active && (pass_idx == AW'(i));
  end

  assign ramp_en_o = (st == ST_RAMP);
  assign ref_sel_o = active && !half;
  assign cnt_up_o  = active && (half ^ cur_neg);
  assign cnt_clr_o = (st == ST_CLR);
  assign busy_o    = (st == ST_CLR) || active;
  assign done_o    = (st == ST_DONE);
endmodule

// File: rtl/wsum_pass_seq_chk.sv
module wsum_pass_seq_chk #(
  parameter int ACC_W    = 6,
  parameter int PASS_MAX = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ramp_en_o,
  input logic                ref_sel_o,
  input logic                cnt_up_o,
  input logic [PASS_MAX-1:0] nbr_sel_o,
  input logic                cnt_clr_o,
  input logic                wclk_o,
  input logic [ACC_W-1:0]    tune_o,
  input logic                busy_o,
  input logic                done_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ramp_en_o && !cnt_clr_o && (nbr_sel_o == '0)));

  p_clr_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_o |=> (!cnt_clr_o && !ramp_en_o && busy_o));

  p_gap_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ramp_en_o) |-> !$past(cnt_clr_o));

  p_ref_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_en_o && $past(ramp_en_o)) |-> $stable(ref_sel_o));

  p_dir_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_en_o && $past(ramp_en_o)) |-> $stable(cnt_up_o));

  p_nbr_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cnt_clr_o) |-> ($countones(nbr_sel_o) == 1));

  p_tune_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_en_o && $past(ramp_en_o)) |-> $stable(tune_o));

  p_wclk_rest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ramp_en_o) |=> !wclk_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(ramp_en_o)) ##1 !done_o);
endmodule

bind wsum_pass_seq wsum_pass_seq_chk #(.ACC_W(ACC_W), .PASS_MAX(PASS_MAX)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ramp_en_o (ramp_en_o),
  .ref_sel_o (ref_sel_o),
  .cnt_up_o  (cnt_up_o),
  .nbr_sel_o (nbr_sel_o),
  .cnt_clr_o (cnt_clr_o),
  .wclk_o    (wclk_o),
  .tune_o    (tune_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/sim_wsum_pass_seq.sv
module sim_wsum_pass_seq;
  localparam int ACC_W    = 6;
  localparam int PASS_MAX = 4;
  localparam int TIME_W   = 8;
  localparam int AW       = 2;
  localparam int PW       = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic [PW-1:0]       n_pass = '0;
  logic [TIME_W-1:0]   rlen = '0, gap = '0;
  logic                we = 1'b0;
  logic [AW-1:0]       waddr = '0;
  logic [ACC_W-1:0]    wword = '0;
  logic                wneg = 1'b0;
  logic                ramp_en, ref_sel, cnt_up, cnt_clr, wclk, busy, done;
  logic [PASS_MAX-1:0] nbr_sel;
  logic [ACC_W-1:0]    tune;

  int n_chk = 0, n_fail = 0;
  int sh_w [PASS_MAX];
  int sh_n [PASS_MAX];

  always #5 clk = ~clk;

  wsum_pass_seq #(.ACC_W(ACC_W), .PASS_MAX(PASS_MAX), .TIME_W(TIME_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_pass_i(n_pass),
    .ramp_len_i(rlen), .gap_i(gap), .tbl_we_i(we), .tbl_addr_i(waddr),
    .tbl_word_i(wword), .tbl_neg_i(wneg), .ramp_en_o(ramp_en),
    .ref_sel_o(ref_sel), .cnt_up_o(cnt_up), .nbr_sel_o(nbr_sel),
    .cnt_clr_o(cnt_clr), .wclk_o(wclk), .tune_o(tune), .busy_o(busy),
    .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tbl_write(input int idx, input int w, input int ng, input bit shadow);
    @(negedge clk);
    we = 1'b1; waddr = AW'(idx); wword = ACC_W'(w); wneg = ng[0];
    @(negedge clk);
    we = 1'b0;
    if (shadow) begin sh_w[idx] = w; sh_n[idx] = ng; end
  endtask

  // full cycle-by-cycle walk of one job against the requirement model
  task automatic run_job(input int np, input int rl, input int gp);
    int ep, erl, egp;
    ep  = (np == 0) ? 1 : ((np > PASS_MAX) ? PASS_MAX : np);
    erl = (rl == 0) ? 1 : rl;
    egp = (gp == 0) ? 1 : gp;
    n_pass = PW'(np); rlen = TIME_W'(rl); gap = TIME_W'(gp);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 cnt_clr", int'(cnt_clr), 1);
    chk("R2 busy", int'(busy), 1);
    chk("R2 ramp_en", int'(ramp_en), 0);
    for (int p = 0; p < ep; p++) begin
      for (int h = 0; h < 2; h++) begin
        for (int g = 0; g < egp; g++) begin
          @(negedge clk);
          chk("R3 gap ramp_en", int'(ramp_en), 0);
          chk("R2 clr once", int'(cnt_clr), 0);
          chk("R4 ref_sel gap", int'(ref_sel), (h == 0) ? 1 : 0);
          chk("R5 cnt_up gap", int'(cnt_up), h ^ sh_n[p]);
          chk("R6 nbr_sel gap", int'(nbr_sel), 1 << p);
        end
        for (int k = 0; k < erl; k++) begin
          @(negedge clk);
          chk("R3 ramp_en", int'(ramp_en), 1);
          chk("R4 ref_sel", int'(ref_sel), (h == 0) ? 1 : 0);
          chk("R5 cnt_up", int'(cnt_up), h ^ sh_n[p]);
          chk("R6 nbr_sel", int'(nbr_sel), 1 << p);
          chk("R7 tune", int'(tune), sh_w[p]);
          chk("R8 wclk", int'(wclk), (((k * sh_w[p]) % (1 << ACC_W)) >> (ACC_W - 1)) & 1);
        end
      end
    end
    @(negedge clk);
    chk("R9 done", int'(done), 1);
    chk("R9 busy", int'(busy), 0);
    chk("R9 ramp_en", int'(ramp_en), 0);
    @(negedge clk);
    chk("R9 done pulse", int'(done), 0);
    chk("R1 idle wclk", int'(wclk), 0);
    chk("R1 idle nbr", int'(nbr_sel), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ramp_en", int'(ramp_en), 0);
    chk("R1 cnt_clr", int'(cnt_clr), 0);
    chk("R1 nbr_sel", int'(nbr_sel), 0);
    chk("R1 wclk", int'(wclk), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_edge_job;
    tbl_write(0, 11, 0, 1);
    tbl_write(1, 28, 0, 1);
    tbl_write(2, 11, 0, 1);
    run_job(3, 40, 3);
  endtask

  task automatic t_signed_extremes;
    tbl_write(0, 5, 1, 1);
    tbl_write(1, 63, 0, 1);
    tbl_write(2, 0, 1, 1);
    run_job(3, 20, 2);
  endtask

  task automatic t_zero_timing;
    run_job(2, 0, 0); // R3: both become one cycle
  endtask

  task automatic t_pass_clamp;
    tbl_write(3, 33, 1, 1);
    run_job(7, 6, 1); // R12 clamp to PASS_MAX
    run_job(0, 6, 1); // R12 zero means one pass
  endtask

  task automatic t_write_busy;
    fork
      run_job(2, 6, 2);
      begin
        repeat (4) @(negedge clk);
        we = 1'b1; waddr = AW'(1); wword = ACC_W'(7); wneg = ~sh_n[1][0];
        @(negedge clk);
        we = 1'b0;
      end
    join
    run_job(2, 6, 2); // R10: stored entry 1 still unchanged
  endtask

  task automatic t_start_busy;
    fork
      run_job(1, 4, 2);
      begin
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    repeat (3) begin
      @(negedge clk);
      chk("R11 no restart busy", int'(busy), 0);
      chk("R11 no restart clr", int'(cnt_clr), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < PASS_MAX; i++) begin sh_w[i] = 0; sh_n[i] = 0; end
    t_reset();
    t_edge_job();
    t_signed_extremes();
    t_zero_timing();
    t_pass_clamp();
    t_write_busy();
    t_start_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule